// File: doc/BRIEF.md
# Slow Timekeeping Tick Source Selector

The block makes a slow timekeeping tick for the rest of the chip. It takes its edges from one of two oscillators. One is an internal RC oscillator, which runs fast and has to be divided down. The other is an external 32 kHz crystal. Each oscillator edge arrives as a one-cycle strobe that is synchronous to the block clock. The result is a one-cycle clock-enable pulse, `slow_tick`, and not a derived clock. A second output, `pin_tick`, is a gated copy of that pulse for an output pin.

Software programs the block through a simple 32-bit write port and a combinational read port. The control register only accepts a write whose upper half carries a guard key, so a stray store cannot switch the timebase. Only the internal path is divided. It goes through a fixed divide-by-`FIX_DIV` stage and then a programmable divide-by-(N+1) stage. The external path passes each crystal strobe straight through. When the external source is selected but no crystal is detected, the block falls back to the internal path unless software has bypassed that fallback.

Top module: `lsc_clk_select`

## Requirements
- R1: After reset, every register reads 0. The internal source is in use (`src_ext`=0), and `slow_tick` and `pin_tick` stay low until a full divided period of internal strobes has arrived.
- R2: A write to the control register (offset 0x00) changes it only when `wr_data[31:16]` equals 0x16AA. A write with any other key leaves it unchanged.
- R3: A read of the control register returns:
  - bit 0: source select (1 = external);
  - bit 4: external-oscillator enable;
  - bit 15: fallback bypass;
  - 0 in every other bit, including bits 31:16.
- R4: On the internal path, `slow_tick` pulses once per `FIX_DIV`*(N+1) internal strobes. The pulse comes in the cycle after the strobe that completes the period. N is bits 4:0 of the prescaler register at offset 0x08, and a read of that register returns N in bits 4:0.
- R5: On the external path, each external strobe produces a `slow_tick` pulse one cycle later, and internal strobes produce none.
- R6: External strobes are ignored while control bit 4 is clear, even when the external source is in use.
- R7: When the external source is selected, bit 15 is clear and `ext_present` is low, the internal divided path drives the tick and `src_ext` reads 0.
- R8: With bit 15 set, the external source stays in use even while `ext_present` is low.
- R9: `pin_tick` equals `slow_tick` while bit 0 of the register at offset 0x60 is set, and stays low otherwise. That register reads back in bit 0.
- R10: The divider counters restart from zero whenever N or the source in use changes, so the first pulse afterwards needs a full new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| int_osc_stb | input | 1 | One-cycle strobe per internal RC oscillator edge |
| ext_osc_stb | input | 1 | One-cycle strobe per external crystal edge |
| ext_present | input | 1 | External crystal detected |
| slow_tick | output | 1 | One-cycle timekeeping enable pulse |
| pin_tick | output | 1 | Gated copy of `slow_tick` for the output pin |
| src_ext | output | 1 | 1 when the external source is in use |

## Verification
The bench builds the block with `FIX_DIV`=4 and keeps the 5-bit prescaler field. With these values it can sweep all 32 prescaler settings, and for each one it checks the exact strobe on which every pulse falls over two full periods, in a few thousand cycles. The same small divider makes the restart cases short. A stale counter value would fire visibly early against the shorter new period. Key rejection, fallback, bypass and gating are each driven through the register port and checked at the outputs.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam logic [15:0] LSC_KEY      = 16'h16AA;
  localparam int          OFS_CTRL     = 'h00;
  localparam int          OFS_PRESCALE = 'h08;
  localparam int          OFS_PIN_GATE = 'h60;
  localparam int          BIT_SRC      = 0;
  localparam int          BIT_EXT_EN   = 4;
  localparam int          BIT_BYPASS   = 15;

  function automatic logic key_ok(input logic [31:0] word);
    return word[31:16] == LSC_KEY;
  endfunction

  function automatic int unsigned tick_period(input int unsigned fix_div,
                                              input int unsigned n);
    return fix_div * (n + 1);
  endfunction
endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              sel_ext,
  output logic              ext_en,
  output logic              bypass,
  output logic [N_W-1:0]    pre_n,
  output logic              pin_en
);
  logic wr_ctrl, wr_pre, wr_gate, key_hit;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
  assign wr_pre  = wr_en && (wr_addr == ADDR_W'(OFS_PRESCALE));
  assign wr_gate = wr_en && (wr_addr == ADDR_W'(OFS_PIN_GATE));
  assign key_hit = key_ok(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_ext <= 1'b0;
      ext_en  <= 1'b0;
      bypass  <= 1'b0;
      pre_n   <= '0;
      pin_en  <= 1'b0;
    end else begin
      if (wr_ctrl && key_hit) begin
        sel_ext <= wr_data[BIT_SRC];
        ext_en  <= wr_data[BIT_EXT_EN];
        bypass  <= wr_data[BIT_BYPASS];
      end
      if (wr_pre)  pre_n  <= wr_data[N_W-1:0];
      if (wr_gate) pin_en <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFS_CTRL)) begin
      rd_data[BIT_SRC]    = sel_ext;
      rd_data[BIT_EXT_EN] = ext_en;
      rd_data[BIT_BYPASS] = bypass;
    end else if (rd_addr == ADDR_W'(OFS_PRESCALE)) begin
      rd_data[N_W-1:0] = pre_n;
    end else if (rd_addr == ADDR_W'(OFS_PIN_GATE)) begin
      rd_data[0] = pin_en;
    end
  end

  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !key_hit) |=> $stable({sel_ext, ext_en, bypass})) else $error("key guard"); // R2
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(OFS_CTRL)) |-> (rd_data[31:16] == 16'h0)) else $error("upper bits"); // R3
endmodule

// File: rtl/lsc_src_mux.sv
module lsc_src_mux (
  input  logic sel_ext,
  input  logic ext_en,
  input  logic bypass,
  input  logic ext_present,
  input  logic ext_osc_stb,
  output logic use_ext,
  output logic ext_pulse
);
  // Fallback to the internal path when the crystal is missing, unless bypassed.
  assign use_ext   = sel_ext && (bypass || ext_present);
  assign ext_pulse = ext_osc_stb && ext_en;
endmodule

// File: rtl/lsc_int_div.sv
module lsc_int_div #(
  parameter int FIX_DIV = 32,
  parameter int N_W     = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [N_W-1:0] n,
  input  logic           stb,
  output logic           div_pulse,
  output logic           restart
);
  localparam int FW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
  localparam logic [FW-1:0] FIX_LAST = FW'(FIX_DIV - 1);

  logic [FW-1:0]  fix_cnt;
  logic [N_W-1:0] prog_cnt;
  logic [N_W-1:0] n_q;
  logic           run_q;
  logic           fix_wrap;

  assign restart   = (n != n_q) || (run != run_q);
  assign fix_wrap  = (fix_cnt == FIX_LAST);
  assign div_pulse = run && !restart && stb && fix_wrap && (prog_cnt == n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      run_q <= 1'b1;
    end else begin
      n_q   <= n;
      run_q <= run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_cnt  <= '0;
      prog_cnt <= '0;
    end else if (restart || !run) begin
      fix_cnt  <= '0;
      prog_cnt <= '0;
    end else if (stb) begin
      if (fix_wrap) begin
        fix_cnt  <= '0;
        prog_cnt <= (prog_cnt == n) ? '0 : prog_cnt + 1'b1;
      end else begin
        fix_cnt <= fix_cnt + 1'b1;
      end
    end
  end

  AST_PROG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (prog_cnt <= n)) else $error("prog range"); // R4
  AST_FIX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fix_cnt <= FIX_LAST) else $error("fix range"); // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (fix_cnt == '0 && prog_cnt == '0)) else $error("restart"); // R10
endmodule

// File: rtl/lsc_clk_select.sv
module lsc_clk_select #(
  parameter int ADDR_W  = 8,
  parameter int FIX_DIV = 32,
  parameter int N_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              int_osc_stb,
  input  logic              ext_osc_stb,
  input  logic              ext_present,
  output logic              slow_tick,
  output logic              pin_tick,
  output logic              src_ext
);
  logic           sel_ext, ext_en, bypass, pin_en;
  logic [N_W-1:0] pre_n;
  logic           use_ext, ext_pulse, div_pulse, restart;
  logic           tick_q;

  lsc_regs #(.ADDR_W(ADDR_W), .N_W(N_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sel_ext(sel_ext), .ext_en(ext_en),
    .bypass(bypass), .pre_n(pre_n), .pin_en(pin_en)
  );

  lsc_src_mux u_mux (
    .sel_ext(sel_ext), .ext_en(ext_en), .bypass(bypass), .ext_present(ext_present),
    .ext_osc_stb(ext_osc_stb), .use_ext(use_ext), .ext_pulse(ext_pulse)
  );

  lsc_int_div #(.FIX_DIV(FIX_DIV), .N_W(N_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(!use_ext), .n(pre_n), .stb(int_osc_stb),
    .div_pulse(div_pulse), .restart(restart)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= use_ext ? ext_pulse : div_pulse;
  end

  assign slow_tick = tick_q;
  assign pin_tick  = tick_q && pin_en;
  assign src_ext   = use_ext;

  AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && ext_osc_stb && ext_en) |=> slow_tick) else $error("ext pass"); // R5
  AST_EXT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && !ext_en) |=> !slow_tick) else $error("ext disabled"); // R6
  AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext && !bypass && !ext_present) |-> !src_ext) else $error("fallback"); // R7
  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext && bypass) |-> src_ext) else $error("bypass"); // R8
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pin_tick |-> slow_tick) else $error("pin gate"); // R9
endmodule

// File: tb/test_lsc_clk_select.sv
`timescale 1ns/1ps
module test_lsc_clk_select;
  localparam int ADDR_W = 8;
  localparam int FIX    = 4;
  localparam int N_W    = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic int_stb = 1'b0, ext_stb = 1'b0, ext_present = 1'b0;
  logic slow_tick, pin_tick, src_ext;
  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lsc_clk_select #(.ADDR_W(ADDR_W), .FIX_DIV(FIX), .N_W(N_W)) i_lsc_clk_select (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .int_osc_stb(int_stb), .ext_osc_stb(ext_stb),
    .ext_present(ext_present), .slow_tick(slow_tick), .pin_tick(pin_tick), .src_ext(src_ext)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    rd_addr = ADDR_W'(addr);
    #1 data = rd_data;
  endtask

  // One strobe; returns the tick seen in the cycle after it.
  task automatic pulse_int(output logic tick, output logic ptick);
    @(negedge clk); int_stb = 1'b1;
    @(negedge clk); int_stb = 1'b0;
    tick = slow_tick; ptick = pin_tick;
  endtask

  task automatic pulse_ext(output logic tick);
    @(negedge clk); ext_stb = 1'b1;
    @(negedge clk); ext_stb = 1'b0;
    tick = slow_tick;
  endtask

  // Number of strobes whose tick disagrees with period-based expectation.
  task automatic run_int(input int n, input int count, output int bad);
    logic t, p;
    bad = 0;
    for (int i = 0; i < count; i++) begin
      pulse_int(t, p);
      if (t !== (((i + 1) % (FIX * (n + 1))) == 0)) bad++;
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic [15:0] key, input logic sel,
                                            input logic en, input logic byp);
    return {key, byp, 10'b0, en, 3'b0, sel};
  endfunction

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic t, p;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); check("R1 ctrl", v, 0);
    rd(8'h08, v); check("R1 prescale", v, 0);
    rd(8'h60, v); check("R1 gate", v, 0);
    check("R1 src", src_ext, 0);
    check("R1 tick", slow_tick, 0);
    run_int(0, FIX, bad); check("R1 first period", bad, 0);

    // R2 wrong key ignored, R3 readback
    wr(8'h00, ctrl_word(16'h16AB, 1, 1, 1));
    rd(8'h00, v); check("R2 bad key", v, 0);
    wr(8'h00, ctrl_word(16'h16AA, 0, 1, 1) | 32'h0000_7FEE);
    rd(8'h00, v); check("R3 readback", v, 32'h0000_8010);
    wr(8'h00, ctrl_word(16'h0000, 1, 0, 0));
    rd(8'h00, v); check("R2 zero key", v, 32'h0000_8010);
    wr(8'h00, ctrl_word(16'h16AA, 0, 0, 0));
    rd(8'h00, v); check("R2 good key", v, 0);

    // R4 sweep of every N
    for (int n = 0; n < (1 << N_W); n++) begin
      wr(8'h08, 32'hFFFF_FFE0 | n);
      rd(8'h08, v); check("R4 readback", v, n);
      run_int(n, 2 * FIX * (n + 1), bad); check("R4 period", bad, 0);
    end

    // R9 gate
    wr(8'h08, 0);
    for (int i = 0; i < FIX; i++) pulse_int(t, p);
    check("R9 gated off", {t, p}, 2'b10);
    wr(8'h60, 1);
    rd(8'h60, v); check("R9 readback", v, 1);
    for (int i = 0; i < FIX; i++) pulse_int(t, p);
    check("R9 gated on", {t, p}, 2'b11);

    // R10 restart on N change
    wr(8'h08, 2);
    for (int i = 0; i < 5; i++) pulse_int(t, p);
    wr(8'h08, 1);
    run_int(1, 2 * FIX * 2, bad); check("R10 N change", bad, 0);

    // R8 bypass keeps external without presence; R5 pass-through
    ext_present = 1'b0;
    wr(8'h00, ctrl_word(16'h16AA, 1, 1, 1));
    check("R8 src", src_ext, 1);
    pulse_ext(t); check("R5 ext tick", t, 1);
    @(negedge clk); check("R5 one cycle", slow_tick, 0);
    bad = 0;
    for (int i = 0; i < 3 * FIX * 2; i++) begin pulse_int(t, p); if (t) bad++; end
    check("R5 int ignored", bad, 0);

    // R6 ext enable clear
    wr(8'h00, ctrl_word(16'h16AA, 1, 0, 1));
    pulse_ext(t); check("R6 ext off", t, 0);

    // R10 restart on source change: partial count, go external and back
    wr(8'h00, ctrl_word(16'h16AA, 0, 0, 0));
    for (int i = 0; i < 5; i++) pulse_int(t, p);
    wr(8'h00, ctrl_word(16'h16AA, 1, 1, 1));
    wr(8'h00, ctrl_word(16'h16AA, 0, 0, 0));
    run_int(1, FIX * 2, bad); check("R10 source change", bad, 0);

    // R7 fallback without presence
    wr(8'h00, ctrl_word(16'h16AA, 1, 1, 0));
    check("R7 src", src_ext, 0);
    pulse_ext(t); check("R7 ext ignored", t, 0);
    run_int(1, FIX * 2, bad); check("R7 internal used", bad, 0);
    ext_present = 1'b1;
    @(negedge clk); check("R7 present src", src_ext, 1);
    pulse_ext(t); check("R5 ext after present", t, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule